// File: doc/BRIEF.md
# Multi-Mode Multiply Slice

A pipelined arithmetic slice built around four 18x18 multiplier lanes. The same four lanes are grouped into a different number of elements according to a mode input. They can form four independent multipliers, two multiply-accumulators, two multipliers with a pairwise sum or difference, or a single element. That single element adds or subtracts two products per pair, sums the two pairs and accumulates the result. Results appear on four 52-bit output slots. Element `e` always drives slot `e`, and slots with no element read zero.

Each lane has an A and a B operand register. A register loads either from its own port slice or, as a shift chain, from the register of the lane below it. How an element reads its operands (signed or unsigned) can be fixed at configuration time or switched every cycle. The same choice applies to whether it adds or subtracts. The per-cycle controls travel down the pipeline with their data. There are three register stages: operand, product, and output/accumulator. A single clock enable freezes all three stages together, and a synchronous reset clears them.

Top module: `dsp_quad_slice`

## Requirements
- R1: In mode 0 (independent multiply), slot k holds the product of lane k's A and B registers, sign- or zero-extended to 52 bits.
- R2: In mode 1 (multiply-accumulate), element e uses lane 2e and accumulates its product into slot e. Lanes 1 and 3 are unused, and slots 2 and 3 read zero.
- R3: In mode 2 (multiply-add), slot e holds P(2e)+P(2e+1), or P(2e)-P(2e+1) when subtracting. Slots 2 and 3 read zero.
- R4: In mode 3 (multiply-add-accumulate), slot 0 accumulates (P0±P1)+(P2±P3), with one add/subtract choice for both pairs. Slots 1 to 3 read zero.
- R5: Each element has a "first lane": lane k in modes 0 and 1, lane 2e in mode 2, and lane 0 in mode 3. The effective signedness of an element is sign_in[first lane] when cfg_sign_dyn=1, and cfg_sign_fix otherwise. A value of 1 means both operands of every lane in the element are signed.
- R6: The effective subtract flag is sub_in[first lane] when cfg_sub_dyn=1, and cfg_sub_fix otherwise. A value of 1 means subtract. In mode 1 it negates the term being accumulated. In modes 2 and 3 it selects the difference of each product pair.
- R7: clr_in[first lane]=1 makes the accumulating element load its current term instead of adding it to the old value. It also clears that slot's overflow flag.
- R8: ovf[s] sets when an accumulation into slot s overflows the signed 52-bit range. It then stays set until a clear or a reset. It is never set in modes 0 and 2.
- R9: For k≥1, a_shift[k-1]=1 makes lane k's A register load lane k-1's A register value from before the edge instead of its port. b_shift does the same for B. Lane 0 always loads from its port.
- R10: With ce=0, no register of any stage changes.
- R11: rst=1 at a clock edge clears every register and output, whatever the value of ce.
- R12: Operands and controls presented before clock edge n affect the outputs from edge n+2 onward. This is the third edge that captures them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for all stages |
| cfg_mode | input | 2 | Element grouping: 0 multiply, 1 multiply-accumulate, 2 multiply-add, 3 multiply-add-accumulate |
| cfg_sign_dyn | input | 1 | 1: signedness from sign_in each cycle |
| cfg_sign_fix | input | 1 | Fixed signedness when not dynamic (1 signed) |
| cfg_sub_dyn | input | 1 | 1: add/subtract from sub_in each cycle |
| cfg_sub_fix | input | 1 | Fixed subtract flag when not dynamic |
| a_in | input | 72 | A operands, lane k at bits k*18 +: 18 |
| b_in | input | 72 | B operands, lane k at bits k*18 +: 18 |
| a_shift | input | 3 | Bit k-1: lane k A loads from lane k-1 |
| b_shift | input | 3 | Bit k-1: lane k B loads from lane k-1 |
| sign_in | input | 4 | Per-lane dynamic signedness |
| sub_in | input | 4 | Per-lane dynamic subtract |
| clr_in | input | 4 | Per-lane accumulator clear |
| res | output | 208 | Result slots, slot s at bits s*52 +: 52 |
| ovf | output | 4 | Sticky overflow per slot |

## Verification
The assertions assume that the configuration inputs (mode, fixed/dynamic selects and fixed values) only change while rst is high. The stall, sticky-overflow and unused-slot properties would otherwise compare state built under one grouping against another. The stimulus changes configuration only inside a reset pulse, then sweeps every mode against each signedness and add/subtract setting. Within each setting it randomises operands (weighted toward zero, one and extreme values), shift selects, per-cycle controls, clears and clock-enable gaps.

// File: rtl/dsp_quad_slice.sv
module dsp_quad_slice #(
  parameter int W     = 18,
  parameter int ACC_W = 52
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_sign_dyn,
  input  logic              cfg_sign_fix,
  input  logic              cfg_sub_dyn,
  input  logic              cfg_sub_fix,
  input  logic [4*W-1:0]    a_in,
  input  logic [4*W-1:0]    b_in,
  input  logic [2:0]        a_shift,
  input  logic [2:0]        b_shift,
  input  logic [3:0]        sign_in,
  input  logic [3:0]        sub_in,
  input  logic [3:0]        clr_in,
  output logic [4*ACC_W-1:0] res,
  output logic [3:0]        ovf
);
  localparam int NL = 4;
  localparam int PW = 2*W + 2;
  localparam logic [1:0] M_MUL = 2'd0, M_MAC = 2'd1, M_MADD = 2'd2, M_MSUM = 2'd3;

  function automatic logic [1:0] first_lane(input logic [1:0] m, input logic [1:0] k);
    case (m)
      M_MADD:  return {k[1], 1'b0};
      M_MSUM:  return 2'd0;
      default: return k;
    endcase
  endfunction

  function automatic logic add_of(input logic [ACC_W-1:0] x, input logic [ACC_W-1:0] t,
                                  input logic [ACC_W-1:0] s);
    return (x[ACC_W-1] == t[ACC_W-1]) && (s[ACC_W-1] != x[ACC_W-1]);
  endfunction

  logic [W-1:0]          a_r [NL];
  logic [W-1:0]          b_r [NL];
  logic [W-1:0]          a_src [NL];
  logic [W-1:0]          b_src [NL];
  logic [NL-1:0]         sg_r, sb_r, cl_r, sb_p, cl_p;
  logic signed [PW-1:0]  p_r [NL];
  logic [ACC_W-1:0]      pe [NL];
  logic [ACC_W-1:0]      acc [NL];
  logic [ACC_W-1:0]      nacc [NL];
  logic [NL-1:0]         novf;

  always_comb begin
    a_src[0] = a_in[W-1:0];
    b_src[0] = b_in[W-1:0];
    for (int k = 1; k < NL; k++) begin
      a_src[k] = a_shift[k-1] ? a_r[k-1] : a_in[k*W +: W];
      b_src[k] = b_shift[k-1] ? b_r[k-1] : b_in[k*W +: W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NL; k++) begin
        a_r[k] <= '0;
        b_r[k] <= '0;
        p_r[k] <= '0;
      end
      sg_r <= '0; sb_r <= '0; cl_r <= '0; sb_p <= '0; cl_p <= '0;
    end else if (ce) begin
      for (int k = 0; k < NL; k++) begin
        a_r[k]  <= a_src[k];
        b_r[k]  <= b_src[k];
        sg_r[k] <= cfg_sign_dyn ? sign_in[first_lane(cfg_mode, 2'(k))] : cfg_sign_fix;
        sb_r[k] <= cfg_sub_dyn ? sub_in[first_lane(cfg_mode, 2'(k))] : cfg_sub_fix;
        cl_r[k] <= clr_in[first_lane(cfg_mode, 2'(k))];
        p_r[k]  <= $signed({sg_r[k] & a_r[k][W-1], a_r[k]}) *
                   $signed({sg_r[k] & b_r[k][W-1], b_r[k]});
      end
      sb_p <= sb_r;
      cl_p <= cl_r;
    end
  end

  for (genvar k = 0; k < NL; k++) begin : g_lane
    assign pe[k] = {{(ACC_W-PW){p_r[k][PW-1]}}, p_r[k]};
    assign res[k*ACC_W +: ACC_W] = acc[k];
  end

  always_comb begin
    logic [ACC_W-1:0] t, s;
    t = '0;
    s = '0;
    for (int k = 0; k < NL; k++) begin
      nacc[k] = '0;
      novf[k] = 1'b0;
    end
    case (cfg_mode)
      M_MUL: begin
        for (int k = 0; k < NL; k++) nacc[k] = pe[k];
      end
      M_MAC: begin
        for (int e = 0; e < NL/2; e++) begin
          t = sb_p[2*e] ? -pe[2*e] : pe[2*e];
          s = acc[e] + t;
          nacc[e] = cl_p[2*e] ? t : s;
          novf[e] = !cl_p[2*e] && (ovf[e] || add_of(acc[e], t, s));
        end
      end
      M_MADD: begin
        for (int e = 0; e < NL/2; e++)
          nacc[e] = sb_p[2*e] ? pe[2*e] - pe[2*e+1] : pe[2*e] + pe[2*e+1];
      end
      default: begin
        t = sb_p[0] ? (pe[0] - pe[1]) + (pe[2] - pe[3])
                    : (pe[0] + pe[1]) + (pe[2] + pe[3]);
        s = acc[0] + t;
        nacc[0] = cl_p[0] ? t : s;
        novf[0] = !cl_p[0] && (ovf[0] || add_of(acc[0], t, s));
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NL; k++) acc[k] <= '0;
      ovf <= '0;
    end else if (ce) begin
      for (int k = 0; k < NL; k++) acc[k] <= nacc[k];
      ovf <= novf;
    end
  end

  // Configuration inputs are taken as stable outside reset.
  assert_stall_R10: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(res) && $stable(ovf)));

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (res == '0 && ovf == '0));

  assert_no_ovf_nonacc_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == M_MUL || cfg_mode == M_MADD) |-> (ovf == '0));

  assert_mac_unused_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == M_MAC) |-> (res[NL*ACC_W-1:2*ACC_W] == '0 && ovf[3:2] == 2'b00));

  assert_msum_unused_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == M_MSUM) |-> (res[NL*ACC_W-1:ACC_W] == '0 && ovf[3:1] == 3'b000));

  for (genvar s = 0; s < NL/2; s++) begin : g_sticky
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      (ovf[s] && ce && !cl_p[2*s]) |=> ovf[s]);
  end
endmodule

// File: tb/dsp_quad_slice_tb.sv
module dsp_quad_slice_tb_top;
  localparam int W = 18;
  localparam int A = 52;

  logic clk = 1'b0;
  logic rst = 1'b1, ce = 1'b0;
  logic [1:0] mode = '0;
  logic sdyn = 0, sfix = 0, udyn = 0, ufix = 0;
  logic [4*W-1:0] a_in = '0, b_in = '0;
  logic [2:0] ash = '0, bsh = '0;
  logic [3:0] sgn = '0, sub = '0, clr = '0;
  logic [4*A-1:0] res;
  logic [3:0] ovf;

  int vectors = 0, errors = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  dsp_quad_slice #(.W(W), .ACC_W(A)) dut_i (
    .clk(clk), .rst(rst), .ce(ce), .cfg_mode(mode),
    .cfg_sign_dyn(sdyn), .cfg_sign_fix(sfix), .cfg_sub_dyn(udyn), .cfg_sub_fix(ufix),
    .a_in(a_in), .b_in(b_in), .a_shift(ash), .b_shift(bsh),
    .sign_in(sgn), .sub_in(sub), .clr_in(clr), .res(res), .ovf(ovf));

  logic [W-1:0] ma[4], mb[4];
  bit msg[4], msb[4], mcl[4], psb[4], pcl[4], mo[4];
  longint mp[4], mr[4];
  bit last_rst;

  function automatic int lead(int m, int k);
    if (m == 2) return k - (k % 2);
    if (m == 3) return 0;
    return k;
  endfunction

  function automatic longint ext(logic [W-1:0] v, bit s);
    if (s && v[W-1]) return longint'(v) - (longint'(1) << W);
    return longint'(v);
  endfunction

  function automatic longint wrap(longint v);
    logic [63:0] u;
    logic [A-1:0] t;
    u = v;
    t = u[A-1:0];
    return longint'($signed(t));
  endfunction

  function automatic bit oob(longint v);
    return (v > (longint'(1) <<< (A-1)) - 1) || (v < -(longint'(1) <<< (A-1)));
  endfunction

  task automatic acc_slot(int s, longint t, bit c);
    longint x;
    if (c) begin mr[s] = t; mo[s] = 0; end
    else begin
      x = mr[s] + t;
      mo[s] = mo[s] | oob(x);
      mr[s] = wrap(x);
    end
  endtask

  task automatic model_edge();
    logic [W-1:0] oa[4], ob[4];
    longint t;
    last_rst = rst;
    if (rst) begin
      for (int k = 0; k < 4; k++) begin
        ma[k] = 0; mb[k] = 0; msg[k] = 0; msb[k] = 0; mcl[k] = 0;
        psb[k] = 0; pcl[k] = 0; mp[k] = 0; mr[k] = 0; mo[k] = 0;
      end
      return;
    end
    if (!ce) return;
    case (mode)
      2'd0: for (int k = 0; k < 4; k++) begin mr[k] = mp[k]; mo[k] = 0; end
      2'd1: begin
        for (int e = 0; e < 2; e++) acc_slot(e, psb[2*e] ? -mp[2*e] : mp[2*e], pcl[2*e]);
        mr[2] = 0; mr[3] = 0; mo[2] = 0; mo[3] = 0;
      end
      2'd2: begin
        for (int e = 0; e < 2; e++) mr[e] = psb[2*e] ? mp[2*e] - mp[2*e+1] : mp[2*e] + mp[2*e+1];
        mr[2] = 0; mr[3] = 0;
        for (int k = 0; k < 4; k++) mo[k] = 0;
      end
      default: begin
        t = psb[0] ? (mp[0] - mp[1]) + (mp[2] - mp[3]) : mp[0] + mp[1] + mp[2] + mp[3];
        acc_slot(0, t, pcl[0]);
        for (int k = 1; k < 4; k++) begin mr[k] = 0; mo[k] = 0; end
      end
    endcase
    for (int k = 0; k < 4; k++) begin
      mp[k] = ext(ma[k], msg[k]) * ext(mb[k], msg[k]);
      psb[k] = msb[k]; pcl[k] = mcl[k];
      oa[k] = ma[k]; ob[k] = mb[k];
    end
    for (int k = 0; k < 4; k++) begin
      ma[k] = (k > 0 && ash[k-1]) ? oa[k-1] : a_in[k*W +: W];
      mb[k] = (k > 0 && bsh[k-1]) ? ob[k-1] : b_in[k*W +: W];
      msg[k] = sdyn ? sgn[lead(mode, k)] : sfix;
      msb[k] = udyn ? sub[lead(mode, k)] : ufix;
      mcl[k] = clr[lead(mode, k)];
    end
  endtask

  task automatic check_all();
    string tag;
    logic [A-1:0] exp_r;
    if (last_rst) tag = "R11 reset";
    else case (mode)
      2'd0: tag = "R1 mult";
      2'd1: tag = "R2 mac";
      2'd2: tag = "R3 madd";
      default: tag = "R4 msum";
    endcase
    for (int s = 0; s < 4; s++) begin
      exp_r = mr[s][A-1:0];
      vectors++;
      if (res[s*A +: A] !== exp_r) begin
        errors++;
        $display("FAIL %s slot %0d: got %h expected %h", tag, s, res[s*A +: A], exp_r);
      end
    end
    vectors++;
    if (ovf !== {mo[3], mo[2], mo[1], mo[0]}) begin
      errors++;
      $display("FAIL R8 ovf (%s): got %b expected %b", tag, ovf, {mo[3], mo[2], mo[1], mo[0]});
    end
  endtask

  task automatic step();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic expect_val(string req, logic [A-1:0] got, logic [A-1:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  function automatic logic [W-1:0] pick();
    logic [31:0] r;
    r = rnd();
    case (r[2:0])
      3'd0: return '0;
      3'd1: return '1;
      3'd2: return 18'h20000;
      3'd3: return 18'h1FFFF;
      3'd4: return 18'd1;
      default: return r[31:14];
    endcase
  endfunction

  task automatic do_reset(int m, bit sd, bit sf, bit ud, bit uf);
    rst = 1; ce = rnd() % 2;
    mode = 2'(m); sdyn = sd; sfix = sf; udyn = ud; ufix = uf;
    step();
    step();
    rst = 0;
  endtask

  initial begin
    @(negedge clk);
    // R12: a single vector on lane 0 reaches slot 0 on the third edge
    clr = '0; ash = '0; bsh = '0;
    do_reset(0, 0, 0, 0, 0);
    ce = 1;
    a_in = '0; b_in = '0;
    a_in[W-1:0] = 18'd3; b_in[W-1:0] = 18'd5;
    step();
    expect_val("R12 edge1", res[A-1:0], '0);
    a_in = '0; b_in = '0;
    step();
    expect_val("R12 edge2", res[A-1:0], '0);
    step();
    expect_val("R12 edge3", res[A-1:0], 52'd15);
    step();
    expect_val("R12 drain", res[A-1:0], '0);

    // Sweep over every mode and control setting.
    // Exercises R5 (signedness), R6 (add/sub), R7 (clear), R9 (shift chain), R10 (stall).
    for (int m = 0; m < 4; m++)
      for (int sc = 0; sc < 3; sc++)
        for (int uc = 0; uc < 3; uc++) begin
          do_reset(m, sc == 2, sc == 1, uc == 2, uc == 1);
          for (int i = 0; i < 60; i++) begin
            for (int k = 0; k < 4; k++) begin
              a_in[k*W +: W] = pick();
              b_in[k*W +: W] = pick();
            end
            ash = rnd() % 8; bsh = rnd() % 8;
            sgn = rnd() % 16; sub = rnd() % 16;
            for (int k = 0; k < 4; k++) clr[k] = (rnd() % 8) == 0;
            ce = (rnd() % 8) != 0;
            step();
          end
        end

    // R8: unsigned maxima in mode 3 overflow after 8193 accumulations, then clear
    ash = '0; bsh = '0; sgn = '0; sub = '0; clr = '0;
    do_reset(3, 0, 0, 0, 0);
    ce = 1; a_in = '1; b_in = '1;
    repeat (8210) step();
    expect_val("R8 overflow set", {51'd0, ovf[0]}, 52'd1);
    clr = 4'b0001;
    step();
    clr = '0;
    repeat (3) step();
    expect_val("R7 clear drops overflow", {51'd0, ovf[0]}, 52'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule